// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits behind a UART deserializer and holds received characters until software or a DMA-free polling loop collects them. Each character arrives on a valid/ready stream together with three per-character line indications (framing, parity, break). The block stores the byte and its flags as one entry in a first-in first-out store. On the read side it presents a 16-bit status-tagged word in which every error condition belongs to the character it accompanies. A fourth flag, overrun, is added when a later character had to be thrown away.

Two independent fill comparisons drive the side outputs. A receive request rises once the fill reaches a programmable threshold. A flow-control stop output tells the remote transmitter to pause once the fill reaches a separate programmable trigger level. When automatic flow control is off, the stop output instead follows a software-controlled level. A software reset request flushes the store, releases the stop output and reports its own completion on an active-low-style status pin.

Back-pressure rules: the input stream is accepted on any cycle where `in_valid` and `in_ready` are both high. The deserializer cannot wait, so a character presented while `in_ready` is low is not held. It is dropped, and that drop is recorded as an overrun on the newest stored entry if the store is full. On the output stream, an entry is removed on any cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` has no effect while `rd_valid` is low.

Top module: `uart_rx_buffer`

## Requirements
- R1: `rd_word` carries the byte in bits 7:0, parity error in bit 10, break in bit 11, framing error in bit 12, overrun in bit 13, an error summary in bit 14 and a character-ready flag in bit 15. Bits 9:8 are always 0.
- R2: Characters leave in arrival order. The store holds DEPTH (default 32) entries, and `in_ready` is 0 while all DEPTH entries are occupied.
- R3: An entry is removed when `rd_valid` and `rd_ready` are both 1. While the store is empty, `rd_valid` is 0, `rd_word` is all zeros (ready bit clear), and `rd_ready` changes nothing.
- R4: `rx_avail` is 1 exactly when at least one character is waiting.
- R5: A character presented while the store is full is discarded. Bit 13 is set on the most recently stored entry, and all other entries are unchanged.
- R6: Bit 14 of `rd_word` is the OR of bits 13, 12, 11 and 10 of the same word.
- R7: `rx_req` is 1 when the fill is at least `rx_thresh` and at least 1. A threshold of 0 behaves like 1.
- R8: With `cts_auto` = 1, `flow_stop` is 1 exactly when the fill is at least `cts_level`. A level above DEPTH never stops the sender, and a level of 0 always does.
- R9: With `cts_auto` = 0, `flow_stop` equals `cts_manual`, regardless of the fill.
- R10: A one-cycle `sw_rst_req` drives `sw_rst_done` to 0 from the next cycle for RST_CYCLES cycles (default 4), then back to 1. While it is 0, `in_ready`, `rd_valid`, `rx_req` and `flow_stop` are 0. Afterwards the store is empty.
- R11: A character accepted at a clock edge is visible on `rd_word`, with `rd_valid` = 1, directly after that edge when the store was empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Deserializer has a character |
| in_ready | output | 1 | Character will be stored this cycle |
| in_data | input | 8 | Received byte |
| in_frm_err | input | 1 | Stop bit was wrong for this character |
| in_par_err | input | 1 | Parity check failed for this character |
| in_brk | input | 1 | Line held low for a whole character |
| rd_valid | output | 1 | A stored character is presented |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_word | output | 16 | Status-tagged character word |
| rx_avail | output | 1 | Status flag: at least one character waiting |
| rx_thresh | input | LVL_W | Fill level for the receive request |
| rx_req | output | 1 | Fill has reached the threshold |
| cts_auto | input | 1 | Receiver drives the flow-control stop |
| cts_level | input | LVL_W | Fill level that stops the remote sender |
| cts_manual | input | 1 | Stop level used when `cts_auto` is 0 |
| flow_stop | output | 1 | 1 asks the remote end to stop sending |
| sw_rst_req | input | 1 | One-cycle software reset request |
| sw_rst_done | output | 1 | 0 while the software reset runs, 1 otherwise |

## Verification
The bench fills the store to exactly DEPTH and pushes one more character. A design that overwrote an entry, advanced the write pointer, or tagged the wrong entry would show up as a wrong byte count or a misplaced bit 13 when the store is drained. It reads the store while it is empty to catch a pointer that slips under back-pressure, and it places both the threshold and the flow trigger at one-off boundaries to catch comparisons that use > where >= is needed. A software reset issued while characters are held and the stop output is high must keep the status low for exactly the programmed number of cycles and leave nothing readable. A flush that is late or too short would leave stale words behind.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef struct packed {
    logic       ovr;
    logic       frm;
    logic       brk;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;

  localparam int WORD_W = 16;

  // word layout: 15 ready, 14 summary, 13 overrun, 12 framing, 11 break, 10 parity
  function automatic logic [WORD_W-1:0] make_word(input logic present, input rx_entry_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    if (present) begin
      w[7:0] = e.data;
      w[10]  = e.par;
      w[11]  = e.brk;
      w[12]  = e.frm;
      w[13]  = e.ovr;
      w[14]  = e.ovr | e.frm | e.brk | e.par;
      w[15]  = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  input  logic          mark_ovr,
  output rx_entry_t     head,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          full
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [AW-1:0]   newest;
  logic [CW-1:0]   count;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign newest = (wr_ptr == '0) ? LAST_IDX : wr_ptr - AW'(1);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
    if (mark_ovr) mem[newest].ovr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign fill  = count;
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

endmodule

// File: rtl/rxbuf_levels.sv
module rxbuf_levels #(
  parameter int CW = 6
) (
  input  logic [CW-1:0] fill,
  input  logic          busy,
  input  logic [CW-1:0] rx_thresh,
  input  logic          cts_auto,
  input  logic [CW-1:0] cts_level,
  input  logic          cts_manual,
  output logic          rx_req,
  output logic          flow_stop
);

  logic thr_hit, cts_hit;

  always_comb begin
    thr_hit   = (fill != '0) && (fill >= rx_thresh);
    cts_hit   = (fill >= cts_level);
    rx_req    = !busy && thr_hit;
    flow_stop = !busy && (cts_auto ? cts_hit : cts_manual);
  end

endmodule

// File: rtl/rxbuf_swrst.sv
module rxbuf_swrst #(
  parameter int RST_CYCLES = 4,
  parameter int TW         = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy
);

  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            timer <= '0;
    else if (req)          timer <= TW'(RST_CYCLES);
    else if (timer != '0)  timer <= timer - TW'(1);
  end

  assign busy = (timer != '0);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int RST_CYCLES = 4,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_frm_err,
  input  logic             in_par_err,
  input  logic             in_brk,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [15:0]      rd_word,
  output logic             rx_avail,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             rx_req,
  input  logic             cts_auto,
  input  logic [LVL_W-1:0] cts_level,
  input  logic             cts_manual,
  output logic             flow_stop,
  input  logic             sw_rst_req,
  output logic             sw_rst_done
);

  rx_entry_t        new_entry, head;
  logic [LVL_W-1:0] fill;
  logic             empty, full, busy;
  logic             push, pop, mark_ovr;

  always_comb begin
    new_entry.ovr  = 1'b0;
    new_entry.frm  = in_frm_err;
    new_entry.brk  = in_brk;
    new_entry.par  = in_par_err;
    new_entry.data = in_data;
  end

  assign in_ready = !full && !busy;
  assign rd_valid = !empty && !busy;
  assign push     = in_valid && in_ready;
  assign pop      = rd_valid && rd_ready;
  assign mark_ovr = in_valid && full && !busy;

  rxbuf_swrst #(.RST_CYCLES(RST_CYCLES)) u_swrst (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (sw_rst_req),
    .busy  (busy)
  );

  rxbuf_store #(.DEPTH(DEPTH), .CW(LVL_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (busy),
    .push       (push),
    .push_entry (new_entry),
    .pop        (pop),
    .mark_ovr   (mark_ovr),
    .head       (head),
    .fill       (fill),
    .empty      (empty),
    .full       (full)
  );

  rxbuf_levels #(.CW(LVL_W)) u_levels (
    .fill       (fill),
    .busy       (busy),
    .rx_thresh  (rx_thresh),
    .cts_auto   (cts_auto),
    .cts_level  (cts_level),
    .cts_manual (cts_manual),
    .rx_req     (rx_req),
    .flow_stop  (flow_stop)
  );

  assign rd_word     = make_word(rd_valid, head);
  assign rx_avail    = rd_valid;
  assign sw_rst_done = !busy;

endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [15:0]      rd_word,
  input logic             rx_avail,
  input logic [LVL_W-1:0] rx_thresh,
  input logic             rx_req,
  input logic             cts_auto,
  input logic             cts_manual,
  input logic             flow_stop,
  input logic             sw_rst_req,
  input logic             sw_rst_done
);

  // R1
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_word[15] && rd_word[9:8] == 2'b00));

  // R3
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_word == 16'h0000));

  // R3
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && sw_rst_done && !sw_rst_req) |=> (rd_valid && $stable(rd_word)));

  // R4
  avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail == rd_valid);

  // R6
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[14] == (|rd_word[13:10]));

  // R7
  thresh_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rx_thresh <= LVL_W'(1)) |-> rx_req);

  // R9
  manual_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_auto && sw_rst_done) |-> (flow_stop == cts_manual));

  // R10
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req |=> !sw_rst_done);

  // R10
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst_done |-> (!in_ready && !rd_valid && !rx_req && !flow_stop));

endmodule

bind uart_rx_buffer rxbuf_checker #(.LVL_W(LVL_W)) i_chk (.*);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;

  localparam int DEPTH = 32;
  localparam int RSTC  = 4;
  localparam int LW    = 6;

  // {frm, brk, par, data, expected word}
  localparam logic [26:0] VEC [6] = '{
    {3'b000, 8'hA5, 16'h80A5},
    {3'b001, 8'h3C, 16'hC43C},
    {3'b010, 8'hFF, 16'hC8FF},
    {3'b100, 8'h00, 16'hD000},
    {3'b111, 8'h5A, 16'hDC5A},
    {3'b000, 8'h81, 16'h8081}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic in_frm_err = 1'b0, in_par_err = 1'b0, in_brk = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_word;
  logic rx_avail, rx_req, flow_stop, sw_rst_done;
  logic [LW-1:0] rx_thresh = 6'd1, cts_level = 6'd32;
  logic cts_auto = 1'b1, cts_manual = 1'b0, sw_rst_req = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH), .RST_CYCLES(RSTC)) i_uart_rx_buffer (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic b, input logic p);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_frm_err = f; in_brk = b; in_par_err = p;
    @(negedge clk);
    in_valid = 1'b0; in_frm_err = 1'b0; in_brk = 1'b0; in_par_err = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [15:0] exp);
    check(req, rd_word, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R3 reset word", rd_word, 16'h0000);
    check("R4 reset avail", {15'b0, rx_avail}, 16'h0000);
    check("R2 reset in_ready", {15'b0, in_ready}, 16'h0001);
    check("R10 reset done", {15'b0, sw_rst_done}, 16'h0001);
    check("R8 reset flow_stop", {15'b0, flow_stop}, 16'h0000);
    check("R7 reset rx_req", {15'b0, rx_req}, 16'h0000);

    // vector table: layout, per-character flags, order
    for (int i = 0; i < 6; i++) push(VEC[i][23:16], VEC[i][26], VEC[i][25], VEC[i][24]);
    check("R4 avail after fill", {15'b0, rx_avail}, 16'h0001);
    for (int i = 0; i < 6; i++) pop_expect("R1 R6 R2 table word", VEC[i][15:0]);
    check("R3 drained valid", {15'b0, rd_valid}, 16'h0000);

    // read while empty, then latency of a new character
    rd_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_ready = 1'b0;
    check("R3 empty read word", rd_word, 16'h0000);
    push(8'h42, 1'b0, 1'b0, 1'b0);
    check("R11 latency valid", {15'b0, rd_valid}, 16'h0001);
    pop_expect("R3 R11 after empty read", 16'h8042);

    // receive threshold boundaries
    rx_thresh = 6'd3;
    push(8'h01, 1'b0, 1'b0, 1'b0);
    push(8'h02, 1'b0, 1'b0, 1'b0);
    check("R7 below threshold", {15'b0, rx_req}, 16'h0000);
    push(8'h03, 1'b0, 1'b0, 1'b0);
    check("R7 at threshold", {15'b0, rx_req}, 16'h0001);
    rx_thresh = 6'd0;
    #0.1;
    check("R7 threshold zero", {15'b0, rx_req}, 16'h0001);
    for (int i = 1; i <= 3; i++) pop_expect("R2 threshold drain", 16'h8000 | 16'(i));
    check("R7 zero fill", {15'b0, rx_req}, 16'h0000);
    rx_thresh = 6'd1;

    // full store, flow trigger, overrun
    for (int i = 0; i < DEPTH; i++) begin
      push(8'(i), 1'b0, 1'b0, 1'b0);
      if (i == DEPTH - 2) check("R8 one below level", {15'b0, flow_stop}, 16'h0000);
    end
    check("R8 at level", {15'b0, flow_stop}, 16'h0001);
    check("R2 full in_ready", {15'b0, in_ready}, 16'h0000);
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      logic ov;
      ov = (i == DEPTH - 1);
      pop_expect("R5 R2 overrun drain", {1'b1, ov, ov, 5'b0, 8'(i)});
    end
    check("R5 extra discarded", {15'b0, rd_valid}, 16'h0000);

    // level above depth never stops, level zero always stops
    cts_level = 6'd33;
    push(8'h10, 1'b0, 1'b0, 1'b0);
    check("R8 level above depth", {15'b0, flow_stop}, 16'h0000);
    cts_level = 6'd0;
    pop_expect("R8 drain", 16'h8010);
    check("R8 level zero", {15'b0, flow_stop}, 16'h0001);

    // manual flow control
    cts_auto = 1'b0; cts_manual = 1'b1; cts_level = 6'd1;
    #0.1;
    check("R9 manual high empty", {15'b0, flow_stop}, 16'h0001);
    cts_manual = 1'b0;
    push(8'h20, 1'b0, 1'b0, 1'b0);
    push(8'h21, 1'b0, 1'b0, 1'b0);
    check("R9 manual low filled", {15'b0, flow_stop}, 16'h0000);

    // software reset with data held and stop asserted
    cts_auto = 1'b1;
    push(8'h22, 1'b0, 1'b0, 1'b0);
    check("R8 pre-reset stop", {15'b0, flow_stop}, 16'h0001);
    @(negedge clk);
    sw_rst_req = 1'b1;
    @(negedge clk);
    sw_rst_req = 1'b0;
    check("R10 released stop", {15'b0, flow_stop}, 16'h0000);
    check("R10 blocked input", {15'b0, in_ready}, 16'h0000);
    check("R10 hidden output", {15'b0, rd_valid}, 16'h0000);
    begin
      int low_cycles;
      low_cycles = 0;
      for (int k = 0; k < 10; k++) begin
        if (!sw_rst_done) low_cycles++;
        @(negedge clk);
      end
      check("R10 busy length", 16'(low_cycles), 16'(RSTC));
    end
    check("R10 done", {15'b0, sw_rst_done}, 16'h0001);
    check("R10 flushed", {15'b0, rd_valid}, 16'h0000);
    check("R10 flushed stop", {15'b0, flow_stop}, 16'h0000);
    push(8'h77, 1'b0, 1'b1, 1'b0);
    pop_expect("R10 R1 after reset", 16'hC877);

    finish_run();
  end

endmodule